// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a 32-bit down-counter behind a small register bus that serves either as a general periodic timer or as a watchdog that requests a system reset. Software writes a start value, sets a clock divider and enables counting. In timer mode, reaching zero raises an interrupt flag and, if enabled, the interrupt line. In watchdog mode, reaching zero instead pulses a reset request for one cycle and leaves a sticky note that a reset was requested. Software keeps the watchdog alive by rewriting the start value before the count runs out.

Watchdog mode is latched. A normal control write can turn it on but never off. The only way out is a two-word key sequence written to a dedicated register on consecutive bus writes. Any other write in between, or a wrong key, leaves the mode set.

Top module: `wdt_guard`

## Requirements
- R1: After `rst`, every register reads 0, and `irq` and `rst_req` are low.
- R2: A write to offset 0x20 stores the start value and loads the live counter with it at once. Offset 0x24 returns the live count, and writes to it are ignored.
- R3: Offset 0x28 holds the control word: bit 0 enable, bit 1 auto-reload, bit 2 interrupt enable, bit 3 watchdog mode, bits 15:8 divider value P. While enabled, the counter steps down once every P+1 clock cycles, counting from the control write that enables it. While disabled, it holds its value.
- R4: In timer mode, a step from 1 to 0 sets bit 0 of offset 0x2C. `irq` follows that flag ANDed with the interrupt enable, one cycle later. Writing 1 to bit 0 of 0x2C clears the flag.
- R5: A step taken while the count is 0 reloads the start value if auto-reload is set; otherwise the count stays at 0 and no new event occurs.
- R6: A control write with bit 3 set enters watchdog mode. A control write with bit 3 clear leaves the mode unchanged.
- R7: In watchdog mode, a step from 1 to 0 drives `rst_req` high for exactly one cycle (the cycle in which the count first reads 0) and sets bit 0 of offset 0x30. It does not set the interrupt flag.
- R8: Bit 0 of 0x30 is cleared only by writing 1 to it or by `rst`. Writing 0 to it has no effect.
- R9: Writing 0x12345678 to offset 0x34 and then 0x87654321 to offset 0x34 on the next bus write clears watchdog mode and leaves the other control bits unchanged. Offset 0x34 reads 0.
- R10: After the first key, any bus write other than the second key at 0x34 cancels the sequence. A wrong value at either step leaves watchdog mode set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the offset presented in the previous cycle |
| irq | output | 1 | Timer interrupt, registered |
| rst_req | output | 1 | One-cycle reset request from watchdog expiry |

## Verification
The hardest states to reach from the ports are those of the unlock sequence: watchdog mode set with the first key accepted, then an unrelated write or a wrong second key. The stimulus enters watchdog mode on purpose by letting a short count expire with the mode bit set. It then tries a cleared mode bit in a control write, a load write between the keys, and a wrong value in each key step. The control word is read back after each attempt, and only then is the correct key pair applied. The single-cycle reset pulse is sampled on the exact cycle worked out from the load value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFS_LOAD  = 8'h20;
  localparam logic [7:0] OFS_COUNT = 8'h24;
  localparam logic [7:0] OFS_CTRL  = 8'h28;
  localparam logic [7:0] OFS_EVT   = 8'h2C;
  localparam logic [7:0] OFS_RSENT = 8'h30;
  localparam logic [7:0] OFS_UNLK  = 8'h34;

  localparam logic [DW-1:0] UNLK_KEY_A = 32'h1234_5678;
  localparam logic [DW-1:0] UNLK_KEY_B = 32'h8765_4321;

  localparam int B_EN   = 0;
  localparam int B_RLD  = 1;
  localparam int B_IE   = 2;
  localparam int B_WD   = 3;
  localparam int B_DIV  = 8;

  typedef enum logic {ULK_IDLE, ULK_ARMED} ulk_state_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;

  assign tick = en && (pcnt == div);

  always_ff @(posedge clk) begin
    if (rst || !en || restart) pcnt <= '0;
    else if (pcnt == div)      pcnt <= '0;
    else                       pcnt <= pcnt + 1'b1;
  end

  // R3: with a divider above zero, ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && !restart) |=> (!tick || div == '0));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  input  logic         reload_en,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         hit
);
  localparam logic [W-1:0] ONE = W'(1);

  assign hit = tick && !load_we && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load_we) cnt <= load_val;
    else if (tick) begin
      if (cnt == '0) begin
        if (reload_en) cnt <= reload_val;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  // R3: count moves only on a step or a load
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_we) |=> $stable(cnt));
  // R4: an event leaves the counter at zero
  a_r4_hit_zero: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == '0));
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              clr_wd
);
  ulk_state_t st;
  logic       at_unlk;

  assign at_unlk = (addr == ADDR_W'(OFS_UNLK));
  assign clr_wd  = (st == ULK_ARMED) && wr && at_unlk && (wdata == UNLK_KEY_B);

  always_ff @(posedge clk) begin
    if (rst) st <= ULK_IDLE;
    else if (wr) begin
      if (st == ULK_IDLE && at_unlk && wdata == UNLK_KEY_A) st <= ULK_ARMED;
      else                                                  st <= ULK_IDLE;
    end
  end

  // R10: every write while armed ends the armed state
  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    (st == ULK_ARMED && wr) |=> (st == ULK_IDLE));
  // R9: a clear only follows an accepted first key
  a_r9_armed_first: assert property (@(posedge clk) disable iff (rst)
    clr_wd |-> ($past(wr) && $past(at_unlk) && $past(wdata) == UNLK_KEY_A));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int CTRL_PAD = DW - B_DIV - PRE_W;

  logic [DW-1:0]    load_q;
  logic [DW-1:0]    cnt;
  logic             en_q, rld_q, ie_q, wd_q;
  logic [PRE_W-1:0] div_q;
  logic             evt_q, rsent_q;
  logic             tick, hit, clr_wd;
  logic             we_load, we_ctrl, we_evt, we_rsent;
  logic [DW-1:0]    rd_mux;

  assign we_load  = bus_wr && (bus_addr == ADDR_W'(OFS_LOAD));
  assign we_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign we_evt   = bus_wr && (bus_addr == ADDR_W'(OFS_EVT));
  assign we_rsent = bus_wr && (bus_addr == ADDR_W'(OFS_RSENT));

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(en_q), .restart(we_load), .div(div_q), .tick(tick)
  );

  wdt_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .load_we(we_load), .load_val(bus_wdata),
    .reload_val(load_q), .reload_en(rld_q), .tick(tick), .cnt(cnt), .hit(hit)
  );

  wdt_unlock #(.ADDR_W(ADDR_W)) u_ulk (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .clr_wd(clr_wd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      en_q   <= 1'b0;
      rld_q  <= 1'b0;
      ie_q   <= 1'b0;
      div_q  <= '0;
    end else begin
      if (we_load) load_q <= bus_wdata;
      if (we_ctrl) begin
        en_q  <= bus_wdata[B_EN];
        rld_q <= bus_wdata[B_RLD];
        ie_q  <= bus_wdata[B_IE];
        div_q <= bus_wdata[B_DIV +: PRE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         wd_q <= 1'b0;
    else if (we_ctrl && bus_wdata[B_WD]) wd_q <= 1'b1;
    else if (clr_wd)                 wd_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q   <= 1'b0;
      rsent_q <= 1'b0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (hit && !wd_q)                evt_q <= 1'b1;
      else if (we_evt && bus_wdata[0]) evt_q <= 1'b0;
      if (hit && wd_q)                   rsent_q <= 1'b1;
      else if (we_rsent && bus_wdata[0]) rsent_q <= 1'b0;
      rst_req <= hit && wd_q;
      irq     <= evt_q && ie_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_LOAD))       rd_mux = load_q;
    else if (bus_addr == ADDR_W'(OFS_COUNT)) rd_mux = cnt;
    else if (bus_addr == ADDR_W'(OFS_CTRL))
      rd_mux = {{CTRL_PAD{1'b0}}, div_q, 4'b0000, wd_q, ie_q, rld_q, en_q};
    else if (bus_addr == ADDR_W'(OFS_EVT))   rd_mux = {{(DW-1){1'b0}}, evt_q};
    else if (bus_addr == ADDR_W'(OFS_RSENT)) rd_mux = {{(DW-1){1'b0}}, rsent_q};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R7: reset request is a single-cycle pulse
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R7: every reset request leaves the sent flag set
  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> rsent_q);
  // R6: watchdog mode only drops through the key sequence
  a_r6_wd_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_q) |-> $past(clr_wd));
  // R8: sent flag only drops on an explicit write of 1
  a_r8_rsent_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(rsent_q) |-> ($past(we_rsent) && $past(bus_wdata[0])));
endmodule

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wdt_guard i_wdt_guard (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: compares each registered read result
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    // R1 reset state
    chk({31'd0, irq}, 0, "R1 irq");
    chk({31'd0, rst_req}, 0, "R1 rst_req");
    rd(8'h20, 0, "R1 load");
    rd(8'h24, 0, "R1 count");
    rd(8'h28, 0, "R1 ctrl");
    rd(8'h2C, 0, "R1 evt");
    rd(8'h30, 0, "R1 rsent");

    // R2 load writes count, count offset read-only
    wr(8'h20, 32'd77);
    rd(8'h24, 77, "R2 count loaded");
    wr(8'h24, 32'd5);
    rd(8'h24, 77, "R2 count write ignored");
    rd(8'h20, 77, "R2 load readback");

    // R3 control layout and divider
    wr(8'h28, 32'h0000_AB06);
    rd(8'h28, 32'h0000_AB06, "R3 ctrl layout");
    rd(8'h34, 0, "R9 unlock reads zero");
    wr(8'h28, 0);
    wr(8'h20, 5);
    wr(8'h28, 32'h0000_0301);
    wait_n(10);
    wr(8'h28, 0);
    rd(8'h24, 3, "R3 two steps at P=3");
    wait_n(5);
    rd(8'h24, 3, "R3 hold while disabled");

    // R4 timer event and irq
    wr(8'h20, 3);
    wr(8'h28, 32'h5);
    wait_n(3);
    chk({31'd0, irq}, 0, "R4 irq lags flag");
    chk({31'd0, rst_req}, 0, "R7 no reset in timer mode");
    wait_n(1);
    chk({31'd0, irq}, 1, "R4 irq raised");
    rd(8'h2C, 1, "R4 flag set");
    wr(8'h2C, 1);
    wait_n(1);
    chk({31'd0, irq}, 0, "R4 irq cleared");
    rd(8'h2C, 0, "R4 flag cleared");
    rd(8'h24, 0, "R5 no reload stays zero");
    wr(8'h28, 0);

    // R5 auto-reload
    wr(8'h20, 2);
    wr(8'h28, 32'h3);
    wait_n(2);
    wr(8'h28, 0);
    rd(8'h24, 2, "R5 reloaded");
    rd(8'h2C, 1, "R5 event before reload");
    wr(8'h2C, 1);

    // R7 watchdog expiry
    wr(8'h20, 4);
    wr(8'h28, 32'h9);
    wait_n(3);
    chk({31'd0, rst_req}, 0, "R7 before expiry");
    wait_n(1);
    chk({31'd0, rst_req}, 1, "R7 pulse");
    wait_n(1);
    chk({31'd0, rst_req}, 0, "R7 pulse one cycle");
    rd(8'h30, 1, "R7 rsent set");
    rd(8'h2C, 0, "R7 no flag in wd mode");
    chk({31'd0, irq}, 0, "R7 no irq");

    // R8 sticky flag
    wr(8'h30, 0);
    rd(8'h30, 1, "R8 write 0 no effect");
    wr(8'h30, 1);
    rd(8'h30, 0, "R8 write 1 clears");

    // R6 mode bit set-only
    wr(8'h28, 0);
    rd(8'h28, 32'h8, "R6 clear ignored");

    // R10 aborted and wrong sequences
    wr(8'h34, 32'h1234_5678);
    wr(8'h20, 32'd9);
    wr(8'h34, 32'h8765_4321);
    rd(8'h28, 32'h8, "R10 intervening write aborts");
    wr(8'h34, 32'h1234_5679);
    wr(8'h34, 32'h8765_4321);
    rd(8'h28, 32'h8, "R10 wrong first key");
    wr(8'h34, 32'h1234_5678);
    wr(8'h34, 32'h8765_4320);
    rd(8'h28, 32'h8, "R10 wrong second key");

    // R9 correct sequence
    wr(8'h28, 32'h0000_0F0C);
    rd(8'h28, 32'h0000_0F0C, "R9 setup");
    wr(8'h34, 32'h1234_5678);
    wr(8'h34, 32'h8765_4321);
    rd(8'h28, 32'h0000_0F04, "R9 mode cleared");

    // R8 reset clears the sent flag
    wr(8'h20, 1);
    wr(8'h28, 32'h9);
    wait_n(1);
    chk({31'd0, rst_req}, 1, "R7 short expiry");
    rd(8'h30, 1, "R8 set again");
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    rd(8'h30, 0, "R8 cleared by rst");
    rd(8'h28, 0, "R1 ctrl after rst");
    chk({31'd0, rst_req}, 0, "R1 rst_req after rst");
    wait_n(2);
    finish_run();
  end
endmodule